// File: doc/BRIEF.md
# Timed Drawbridge Motor Controller

This block drives one bridge motor from two cooperating timed state machines. A schedule machine runs freely from reset. It holds a "lower" target for a fixed number of clock ticks and then a "raise" target for another fixed number, and repeats this pattern forever. A motor machine turns that target, the two debounced limit-switch levels and its own hold timer into a motor command: off, drive up, or drive down.

When lowering, the motor keeps pushing down for a fixed lock time after the bottom switch closes, so the deck is seated firmly. When raising, the motor stops as soon as the top switch reports closed. The motor machine computes its next state from the target's next value, so a new target and the matching motor response are taken on the same clock edge. The block state is exported as a 3-bit code for observation.

Top module: `bridge_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low puts the target in "lower" and the motor in idle: `state_code` = 3'b000 and both motor outputs low.
- R2: The target reads "lower" (`state_code[2]`=0) for exactly DOWN_TICKS cycles, then "raise" (`state_code[2]`=1) for exactly UP_TICKS cycles, and repeats; each of DOWN_TICKS, UP_TICKS and LOCK_TICKS is at least 1.
- R3: From idle, the motor goes to raising at the next edge if the target is "raise" and the top switch is open, goes to lowering if the target is "lower" and the bottom switch is open, and otherwise stays idle.
- R4: While raising, a closed top switch sampled at an edge returns the motor to idle at that edge.
- R5: While lowering, a closed bottom switch sampled at an edge moves the motor to the lock state. The lock state drives down for exactly LOCK_TICKS cycles and then goes idle, whatever the bottom switch and the target do in the meantime.
- R6: At the edge where the target changes, raising becomes lowering and lowering becomes raising. "Target lower with motor raising" (code 3'b001) and "target raise with motor lowering" (code 3'b110) never appear, so only six combined codes can be observed.
- R7: `state_code[1:0]` encodes the motor: 2'b00 idle, 2'b01 raising, 2'b10 lowering, 2'b11 lock. `motor_up` is high only when raising, and `motor_down` is high only when lowering or in lock, so the two are never high together.
- R8: If both switches read closed at an edge, the motor is idle after that edge and both motor outputs are low. This overrides every other rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_up_closed | input | 1 | Top limit switch, 1 = closed (debounced) |
| sw_down_closed | input | 1 | Bottom limit switch, 1 = closed (debounced) |
| motor_up | output | 1 | Drive the motor upward |
| motor_down | output | 1 | Drive the motor downward |
| state_code | output | 3 | {target, motor state[1:0]} for observation |

## Verification
The bench moves a simple bridge model with the expected motor command. It uses travel times both shorter and longer than the target phases, so target changes land in every motor state. A design that took a target change one cycle late would show code 3'b001 or 3'b110 for one cycle. A lock counter that is off by one shortens or lengthens the downward push after the bottom switch. Injected faults with both switches closed, and a reset applied in the middle of a move, check that the motor drops out at once. A design that let the lock state yield to the target or to the switches would break the lock length, and an off-by-one phase counter would shift every target change that follows.

// File: rtl/bridge_pkg.sv
// Shared types for the drawbridge controller.
// Assumes: the target fits in one bit and the motor state in two bits.
package bridge_pkg;

    typedef enum logic {
        TGT_LOWER = 1'b0,
        TGT_RAISE = 1'b1
    } tgt_t;

    // All four codes are legal, so a corrupted register always lands in a
    // defined state.
    typedef enum logic [1:0] {
        MOT_IDLE  = 2'b00,
        MOT_RAISE = 2'b01,
        MOT_LOWER = 2'b10,
        MOT_LOCK  = 2'b11
    } mot_t;

endpackage

// File: rtl/bridge_span_counter.sv
// Saturating tick counter used to time one span.
// What it does: counts up from zero and stops at last_val. at_end is high
// while the count has reached last_val.
// Assumes: restart is pulsed on the edge that enters a timed span;
// last_val only changes together with a restart.
module bridge_span_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [WIDTH-1:0] last_val,
    output logic             at_end
);

    logic [WIDTH-1:0] cnt_q;

    assign at_end = (cnt_q >= last_val);

    // Purpose: clear on reset or restart, otherwise count up to last_val and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!at_end) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && !restart) |=> at_end);

endmodule

// File: rtl/bridge_target_gen.sv
// Free-running target schedule.
// What it does: holds "lower" for DOWN_TICKS cycles and "raise" for
// UP_TICKS cycles, alternating. It also exposes the value for the next cycle
// so that the motor machine can follow a change on the same edge.
// Assumes: both tick counts are at least 1.
module bridge_target_gen
    import bridge_pkg::*;
#(
    parameter int DOWN_TICKS = 8,
    parameter int UP_TICKS   = 6
) (
    input  logic clk,
    input  logic rst_n,
    output tgt_t tgt_q,
    output tgt_t tgt_nxt
);

    localparam int MAX_TICKS = (DOWN_TICKS > UP_TICKS) ? DOWN_TICKS : UP_TICKS;
    localparam int CW        = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
    localparam logic [CW-1:0] DOWN_LAST = CW'(DOWN_TICKS - 1);
    localparam logic [CW-1:0] UP_LAST   = CW'(UP_TICKS - 1);

    logic          phase_end;
    logic [CW-1:0] phase_last;

    assign phase_last = (tgt_q == TGT_RAISE) ? UP_LAST : DOWN_LAST;

    bridge_span_counter #(.WIDTH(CW)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (phase_end),
        .last_val (phase_last),
        .at_end   (phase_end)
    );

    // Purpose: flip the target when the current phase has run its length.
    always_comb begin
        tgt_nxt = tgt_q;
        if (phase_end) begin
            tgt_nxt = (tgt_q == TGT_RAISE) ? TGT_LOWER : TGT_RAISE;
        end
    end

    // Purpose: target register, starting in "lower".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= TGT_LOWER;
        end else begin
            tgt_q <= tgt_nxt;
        end
    end

    // R2
    tgt_lower_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q == TGT_LOWER && !phase_end) |=> (tgt_q == TGT_LOWER));

    // R2
    tgt_raise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q == TGT_RAISE && !phase_end) |=> (tgt_q == TGT_RAISE));

endmodule

// File: rtl/bridge_motor_fsm.sv
// Motor state machine: idle, raising, lowering, and timed lock.
// What it does: chooses the next motor state from the next target value,
// the two limit switches and the lock timer.
// Assumes: the switches are already debounced and tgt_nxt is the target
// value that becomes valid at the same edge.
module bridge_motor_fsm
    import bridge_pkg::*;
#(
    parameter int LOCK_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  tgt_t tgt_nxt,
    input  logic sw_up_closed,
    input  logic sw_dn_closed,
    output mot_t mot_q
);

    localparam int LW = (LOCK_TICKS > 1) ? $clog2(LOCK_TICKS) : 1;
    localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_TICKS - 1);

    mot_t mot_nxt;
    logic lock_enter;
    logic lock_done;
    logic sw_fault;

    assign sw_fault   = sw_up_closed && sw_dn_closed;
    assign lock_enter = (mot_nxt == MOT_LOCK) && (mot_q != MOT_LOCK);

    bridge_span_counter #(.WIDTH(LW)) u_lock_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (lock_enter),
        .last_val (LOCK_LAST),
        .at_end   (lock_done)
    );

    // Purpose: next-state rules; a switch fault wins, then a target change, then the switches.
    always_comb begin
        mot_nxt = MOT_IDLE;
        if (!sw_fault) begin
            unique case (mot_q)
                MOT_IDLE: begin
                    if (tgt_nxt == TGT_RAISE && !sw_up_closed)      mot_nxt = MOT_RAISE;
                    else if (tgt_nxt == TGT_LOWER && !sw_dn_closed) mot_nxt = MOT_LOWER;
                    else                                            mot_nxt = MOT_IDLE;
                end
                MOT_RAISE: begin
                    if (tgt_nxt == TGT_LOWER) mot_nxt = MOT_LOWER;
                    else if (sw_up_closed)    mot_nxt = MOT_IDLE;
                    else                      mot_nxt = MOT_RAISE;
                end
                MOT_LOWER: begin
                    if (tgt_nxt == TGT_RAISE) mot_nxt = MOT_RAISE;
                    else if (sw_dn_closed)    mot_nxt = MOT_LOCK;
                    else                      mot_nxt = MOT_LOWER;
                end
                MOT_LOCK: begin
                    mot_nxt = lock_done ? MOT_IDLE : MOT_LOCK;
                end
                default: mot_nxt = MOT_IDLE;
            endcase
        end
    end

    // Purpose: motor state register, starting idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mot_q <= MOT_IDLE;
        end else begin
            mot_q <= mot_nxt;
        end
    end

    // R8
    sw_fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_up_closed && sw_dn_closed) |=> (mot_q == MOT_IDLE));

    // R4
    raise_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mot_q == MOT_RAISE && sw_up_closed && tgt_nxt == TGT_RAISE) |=> (mot_q == MOT_IDLE));

    // R5
    lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mot_q == MOT_LOCK) |=> (mot_q == MOT_LOCK || mot_q == MOT_IDLE));

    // R5
    lower_to_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mot_q == MOT_LOWER && sw_dn_closed && !sw_up_closed && tgt_nxt == TGT_LOWER)
            |=> (mot_q == MOT_LOCK));

endmodule

// File: rtl/bridge_ctrl.sv
// Drawbridge controller top: target schedule plus motor machine.
// What it does: drives motor_up / motor_down from the registered motor
// state and exports {target, motor state} as state_code.
// Assumes: synchronous active-low reset; the switches are debounced levels.
module bridge_ctrl
    import bridge_pkg::*;
#(
    parameter int DOWN_TICKS = 8,
    parameter int UP_TICKS   = 6,
    parameter int LOCK_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_up_closed,
    input  logic       sw_down_closed,
    output logic       motor_up,
    output logic       motor_down,
    output logic [2:0] state_code
);

    tgt_t tgt_q;
    tgt_t tgt_nxt;
    mot_t mot_q;

    bridge_target_gen #(
        .DOWN_TICKS (DOWN_TICKS),
        .UP_TICKS   (UP_TICKS)
    ) u_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt_q   (tgt_q),
        .tgt_nxt (tgt_nxt)
    );

    bridge_motor_fsm #(
        .LOCK_TICKS (LOCK_TICKS)
    ) u_motor (
        .clk          (clk),
        .rst_n        (rst_n),
        .tgt_nxt      (tgt_nxt),
        .sw_up_closed (sw_up_closed),
        .sw_dn_closed (sw_down_closed),
        .mot_q        (mot_q)
    );

    // Purpose: decode the motor command and build the observation code.
    always_comb begin
        motor_up   = (mot_q == MOT_RAISE);
        motor_down = (mot_q == MOT_LOWER) || (mot_q == MOT_LOCK);
        state_code = {tgt_q, mot_q};
    end

    // R6
    no_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((tgt_q == TGT_LOWER && mot_q == MOT_RAISE) ||
          (tgt_q == TGT_RAISE && mot_q == MOT_LOWER)));

    // R7
    motor_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_up && motor_down));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_code == 3'b000 && !motor_up && !motor_down));

endmodule

// File: tb/bridge_ctrl_test.sv
// Scoreboard bench: the driver computes the expected state from the
// requirements and queues it, and the monitor compares after each edge.
module bridge_ctrl_test;

    localparam int DT = 8;
    localparam int UT = 6;
    localparam int LT = 3;

    typedef struct {
        logic [2:0] code;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_up = 1'b0;
    logic       sw_dn = 1'b0;
    logic       motor_up;
    logic       motor_down;
    logic [2:0] state_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t q[$];

    // Reference model state: target 0 = lower; motor 0 idle, 1 raise, 2 lower, 3 lock
    int m_tgt = 0, m_tcnt = 0, m_mot = 0, m_lcnt = 0;
    int pos = 0;

    always #4 clk = ~clk;

    bridge_ctrl #(.DOWN_TICKS(DT), .UP_TICKS(UT), .LOCK_TICKS(LT)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_up_closed   (sw_up),
        .sw_down_closed (sw_dn),
        .motor_up       (motor_up),
        .motor_down     (motor_down),
        .state_code     (state_code)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.code = {m_tgt[0], m_mot[1:0]};
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Driver: apply one cycle of inputs and queue the expected post-edge state.
    task automatic step(input bit rst, input bit su, input bit sd);
        int nt, nm;
        string tag;
        @(negedge clk);
        rst_n = !rst;
        sw_up = su;
        sw_dn = sd;
        if (rst) begin
            m_tgt = 0; m_tcnt = 0; m_mot = 0; m_lcnt = 0;
            push("R1");
            return;
        end
        // R2: phase lengths
        nt = m_tgt;
        tag = "R7";
        if (m_tcnt >= ((m_tgt == 1) ? UT : DT) - 1) begin
            nt = 1 - m_tgt;
            m_tcnt = 0;
            tag = "R2";
        end else begin
            m_tcnt++;
        end
        nm = 0;
        if (su && sd) begin
            nm = 0; tag = "R8";
        end else begin
            case (m_mot)
                0: begin
                    if (nt == 1 && !su)      begin nm = 1; tag = "R3"; end
                    else if (nt == 0 && !sd) begin nm = 2; tag = "R3"; end
                    else nm = 0;
                end
                1: begin
                    if (nt == 0)  begin nm = 2; tag = "R6"; end
                    else if (su)  begin nm = 0; tag = "R4"; end
                    else nm = 1;
                end
                2: begin
                    if (nt == 1)  begin nm = 1; tag = "R6"; end
                    else if (sd)  begin nm = 3; tag = "R5"; end
                    else nm = 2;
                end
                default: begin
                    tag = "R5";
                    nm = (m_lcnt >= LT - 1) ? 0 : 3;
                end
            endcase
        end
        if (nm == 3 && m_mot != 3) m_lcnt = 0;
        else if (m_lcnt < LT - 1) m_lcnt++;
        m_tgt = nt;
        m_mot = nm;
        push(tag);
    endtask

    // Plant: bridge position moved by the expected motor command.
    task automatic run_plant(input int travel, input int cycles, input int fault_every);
        for (int i = 0; i < cycles; i++) begin
            bit su, sd;
            int cur;
            su = (pos >= travel);
            sd = (pos <= 0);
            if (fault_every > 0 && (i % fault_every) == fault_every - 1) begin
                su = 1'b1; sd = 1'b1;
            end
            cur = m_mot;
            step(1'b0, su, sd);
            if (cur == 1 && pos < travel) pos++;
            else if (cur >= 2 && pos > 0) pos--;
        end
    endtask

    // Monitor: compare each queued expectation one time unit after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(state_code == e.code, e.tag, "state_code", state_code, e.code);
                check(motor_up == (e.code[1:0] == 2'b01), e.tag, "motor_up", motor_up,
                      e.code[1:0] == 2'b01);
                check(motor_down == e.code[1], e.tag, "motor_down", motor_down, e.code[1]);
                // R7: motor outputs exclusive
                check(!(motor_up && motor_down), "R7", "up&down", motor_up && motor_down, 0);
                // R6: forbidden pairings never observed
                check(state_code != 3'b001 && state_code != 3'b110, "R6", "pairing",
                      state_code, 0);
            end
        end
    end

    initial begin
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        // bridge starts at the bottom: idle until target rises, then up move
        pos = 0;
        run_plant(4, 200, 0);
        // long travel: target changes while raising and lowering
        run_plant(9, 200, 0);
        // short travel with periodic both-closed faults
        run_plant(3, 200, 23);
        // reset in the middle of a move
        step(1'b1, 1'b0, 1'b0);
        run_plant(5, 150, 41);
        // pseudo-random switch levels
        begin
            logic [7:0] lfsr = 8'hA5;
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                step(1'b0, lfsr[0] & lfsr[2], lfsr[1] & lfsr[3]);
            end
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule